// File: doc/BRIEF.md
# Split-Result Integer Multiply Unit

This unit performs signed and unsigned integer multiplication for a 64-bit RISC datapath. Each request supplies two 64-bit operands, a width select (32-bit word or 64-bit doubleword), a signedness flag, an encoding-mode flag and the 5-bit shift-amount field of the instruction. The product is formed at full double width, so the upper half of a signed product comes from a real signed multiply.

In legacy encoding the whole product goes into a pair of accumulator registers, HI and LO. In the new encoding a signed multiply returns only one half of the product, selected by the shift-amount field, and writes it to a general destination register. The accumulators are left untouched in that case. An unsigned word multiply always fills HI and LO, whatever the mode. Operation codes with no defined meaning are reported as illegal and do nothing.

A request is a one-cycle `start_i` pulse. The answer appears exactly two clock cycles later as a one-cycle `valid_o` pulse. A new request may be issued on every cycle.

Top module: `mul_split_unit`

## Requirements
- R1: After reset, `valid_o`, `illegal_o` and `rd_we_o` are low, and `hi_o`, `lo_o` and `rd_data_o` are zero.
- R2: Legacy mode, signed word (`wide_i`=0, `uns_i`=0, `newenc_i`=0): take the 64-bit signed product of the low 32 bits of each operand. LO becomes product bits 31:0 sign-extended from bit 31. HI becomes product bits 63:32 sign-extended from bit 63.
- R3: Legacy mode, signed doubleword (`wide_i`=1): LO becomes bits 63:0 of the signed 128-bit product and HI becomes bits 127:64.
- R4: New mode, signed, `sa_i`=2: the low half of the product goes to `rd_data_o` with `rd_we_o`=1. For a word this is bits 31:0; for a doubleword it is bits 63:0. HI and LO keep their values.
- R5: New mode, signed, `sa_i`=3: the high half of the signed product goes to `rd_data_o` with `rd_we_o`=1. For a word this is bits 63:32; for a doubleword it is bits 127:64. HI and LO keep their values.
- R6: Every word result written to `rd_data_o` is sign-extended from bit 31.
- R7: Unsigned word (`uns_i`=1, `wide_i`=0) in either mode: form the unsigned 64-bit product and write it to LO and HI as in R2, with each half sign-extended from its bit 31. `sa_i` is ignored and `rd_we_o` stays 0.
- R8: New mode, signed, `sa_i` neither 2 nor 3: `illegal_o`=1 together with `valid_o`, `rd_we_o`=0, and HI and LO keep their values.
- R9: Unsigned doubleword (`uns_i`=1, `wide_i`=1) in either mode: `illegal_o`=1, `rd_we_o`=0, and HI and LO keep their values.
- R10: `valid_o` goes high for exactly one cycle, two clock cycles after each `start_i` pulse. Requests on consecutive cycles each complete, in order.
- R11: Word operations use only bits 31:0 of each operand; the upper 32 bits have no effect on the result.
- R12: In legacy mode, `rd_we_o` is never asserted and `sa_i` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request pulse |
| op_a_i | input | 64 | First operand |
| op_b_i | input | 64 | Second operand |
| wide_i | input | 1 | 1 = doubleword, 0 = word |
| uns_i | input | 1 | 1 = unsigned multiply |
| newenc_i | input | 1 | 1 = new split-result encoding |
| sa_i | input | 5 | Shift-amount field (2 = low half, 3 = high half) |
| valid_o | output | 1 | Result pulse, two cycles after start |
| illegal_o | output | 1 | Undefined encoding, qualified by valid_o |
| rd_we_o | output | 1 | Destination register write enable |
| rd_data_o | output | 64 | Destination register data |
| hi_o | output | 64 | HI accumulator |
| lo_o | output | 64 | LO accumulator |

## Verification
The bench targets operand pairs where the sign matters for the high half. Examples are the most negative word and doubleword squared, and -1 times 1. A design that took the high half from an unsigned product would return a large positive value where a small or negative one is expected. Word requests carry random garbage in their upper 32 bits. A design that multiplied full registers, or that forgot to sign-extend a 32-bit half, would show a wrong upper word. New-mode requests are mixed with legacy ones, along with bad shift-amount values and unsigned doubleword codes, to catch a design that corrupts HI/LO when writing rd or that executes an illegal code. Back-to-back requests whose second op reads the accumulators just written expose a latency or ordering error.

// File: rtl/mul_pkg.sv
package mul_pkg;
    // Where a completed multiply deposits its result.
    typedef enum logic [2:0] {
        DST_NONE    = 3'd0,
        DST_HILO_W  = 3'd1,
        DST_HILO_D  = 3'd2,
        DST_RD_LO_W = 3'd3,
        DST_RD_HI_W = 3'd4,
        DST_RD_LO_D = 3'd5,
        DST_RD_HI_D = 3'd6,
        DST_BAD     = 3'd7
    } dest_e;
endpackage

// File: rtl/mul_decode.sv
module mul_decode
    import mul_pkg::*;
#(
    parameter int SA_W  = 5,
    parameter int SA_LO = 2,
    parameter int SA_HI = 3
) (
    input  logic            wide_i,
    input  logic            uns_i,
    input  logic            newenc_i,
    input  logic [SA_W-1:0] sa_i,
    output dest_e           dest_o
);
    localparam logic [SA_W-1:0] SEL_LO = SA_W'(SA_LO);
    localparam logic [SA_W-1:0] SEL_HI = SA_W'(SA_HI);

    always_comb begin
        dest_o = DST_NONE;
        if (uns_i) begin
            // unsigned: word always fills the accumulators, doubleword is undefined
            dest_o = wide_i ? DST_BAD : DST_HILO_W;
        end else if (!newenc_i) begin
            dest_o = wide_i ? DST_HILO_D : DST_HILO_W;
        end else if (sa_i == SEL_LO) begin
            dest_o = wide_i ? DST_RD_LO_D : DST_RD_LO_W;
        end else if (sa_i == SEL_HI) begin
            dest_o = wide_i ? DST_RD_HI_D : DST_RD_HI_W;
        end else begin
            dest_o = DST_BAD;
        end
    end
endmodule

// File: rtl/mul_array.sv
module mul_array #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0]   op_a_i,
    input  logic [XLEN-1:0]   op_b_i,
    input  logic              wide_i,
    input  logic              uns_i,
    output logic [2*XLEN-1:0] prod_o
);
    localparam int PW   = 2 * XLEN;
    localparam int HALF = XLEN / 2;

    logic [1:0][XLEN-1:0] ops;
    logic [1:0][PW-1:0]   ext;

    assign ops[0] = op_a_i;
    assign ops[1] = op_b_i;

    // Both operands get the same width/sign treatment.
    for (genvar g = 0; g < 2; g++) begin : g_ext
        logic fill_w;
        assign fill_w = uns_i ? 1'b0 : ops[g][HALF-1];
        always_comb begin
            if (wide_i)
                ext[g] = {{XLEN{ops[g][XLEN-1]}}, ops[g]};
            else
                ext[g] = {{(PW-HALF){fill_w}}, ops[g][HALF-1:0]};
        end
    end

    // Low PW bits of a product of sign-extended values equal the signed product.
    assign prod_o = ext[0] * ext[1];
endmodule

// File: rtl/mul_format.sv
module mul_format
    import mul_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  dest_e             dest_i,
    input  logic [2*XLEN-1:0] prod_i,
    input  logic [XLEN-1:0]   hi_cur_i,
    input  logic [XLEN-1:0]   lo_cur_i,
    output logic [XLEN-1:0]   hi_nxt_o,
    output logic [XLEN-1:0]   lo_nxt_o,
    output logic [XLEN-1:0]   rd_o,
    output logic              rd_we_o,
    output logic              bad_o
);
    localparam int HALF = XLEN / 2;

    logic [XLEN-1:0] w_lo, w_hi, d_lo, d_hi;

    assign w_lo = {{HALF{prod_i[HALF-1]}}, prod_i[HALF-1:0]};
    assign w_hi = {{HALF{prod_i[XLEN-1]}}, prod_i[XLEN-1:HALF]};
    assign d_lo = prod_i[XLEN-1:0];
    assign d_hi = prod_i[2*XLEN-1:XLEN];

    always_comb begin
        hi_nxt_o = hi_cur_i;
        lo_nxt_o = lo_cur_i;
        rd_o     = '0;
        rd_we_o  = 1'b0;
        bad_o    = 1'b0;
        unique case (dest_i)
            DST_HILO_W:  begin hi_nxt_o = w_hi; lo_nxt_o = w_lo; end
            DST_HILO_D:  begin hi_nxt_o = d_hi; lo_nxt_o = d_lo; end
            DST_RD_LO_W: begin rd_o = w_lo; rd_we_o = 1'b1; end
            DST_RD_HI_W: begin rd_o = w_hi; rd_we_o = 1'b1; end
            DST_RD_LO_D: begin rd_o = d_lo; rd_we_o = 1'b1; end
            DST_RD_HI_D: begin rd_o = d_hi; rd_we_o = 1'b1; end
            DST_BAD:     bad_o = 1'b1;
            default:     ;
        endcase
    end
endmodule

// File: rtl/mul_split_unit.sv
module mul_split_unit
    import mul_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int SA_W  = 5,
    parameter int SA_LO = 2,
    parameter int SA_HI = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [XLEN-1:0] op_a_i,
    input  logic [XLEN-1:0] op_b_i,
    input  logic            wide_i,
    input  logic            uns_i,
    input  logic            newenc_i,
    input  logic [SA_W-1:0] sa_i,
    output logic            valid_o,
    output logic            illegal_o,
    output logic            rd_we_o,
    output logic [XLEN-1:0] rd_data_o,
    output logic [XLEN-1:0] hi_o,
    output logic [XLEN-1:0] lo_o
);
    localparam int PW   = 2 * XLEN;
    localparam int HALF = XLEN / 2;

    typedef struct packed {
        logic            s1_vld;
        dest_e           s1_dest;
        logic [PW-1:0]   s1_prod;
        logic            s2_vld;
        logic            s2_bad;
        logic            s2_we;
        logic [XLEN-1:0] s2_rd;
        logic [XLEN-1:0] hi;
        logic [XLEN-1:0] lo;
    } state_t;

    state_t st_d, st_q;

    dest_e           dec_dest;
    logic [PW-1:0]   arr_prod;
    logic [XLEN-1:0] fmt_hi, fmt_lo, fmt_rd;
    logic            fmt_we, fmt_bad;

    mul_decode #(.SA_W(SA_W), .SA_LO(SA_LO), .SA_HI(SA_HI)) u_dec (
        .wide_i   (wide_i),
        .uns_i    (uns_i),
        .newenc_i (newenc_i),
        .sa_i     (sa_i),
        .dest_o   (dec_dest)
    );

    mul_array #(.XLEN(XLEN)) u_arr (
        .op_a_i (op_a_i),
        .op_b_i (op_b_i),
        .wide_i (wide_i),
        .uns_i  (uns_i),
        .prod_o (arr_prod)
    );

    mul_format #(.XLEN(XLEN)) u_fmt (
        .dest_i   (st_q.s1_dest),
        .prod_i   (st_q.s1_prod),
        .hi_cur_i (st_q.hi),
        .lo_cur_i (st_q.lo),
        .hi_nxt_o (fmt_hi),
        .lo_nxt_o (fmt_lo),
        .rd_o     (fmt_rd),
        .rd_we_o  (fmt_we),
        .bad_o    (fmt_bad)
    );

    always_comb begin
        st_d         = st_q;
        // stage 1: decode and multiply
        st_d.s1_vld  = start_i;
        st_d.s1_dest = start_i ? dec_dest : DST_NONE;
        st_d.s1_prod = start_i ? arr_prod : st_q.s1_prod;
        // stage 2: steer the product
        st_d.s2_vld  = st_q.s1_vld;
        st_d.s2_bad  = st_q.s1_vld & fmt_bad;
        st_d.s2_we   = st_q.s1_vld & fmt_we;
        st_d.s2_rd   = st_q.s1_vld ? fmt_rd : st_q.s2_rd;
        if (st_q.s1_vld) begin
            st_d.hi = fmt_hi;
            st_d.lo = fmt_lo;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o   = st_q.s2_vld;
    assign illegal_o = st_q.s2_bad;
    assign rd_we_o   = st_q.s2_we;
    assign rd_data_o = st_q.s2_rd;
    assign hi_o      = st_q.hi;
    assign lo_o      = st_q.lo;

    // R10: fixed two-cycle latency
    assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> ##1 valid_o);
    assert_no_spurious_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(start_i, 2));

    // R4, R5, R8, R9: accumulators move only on a legal accumulator-writing result
    assert_hilo_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(hi_o) || !$stable(lo_o)) |-> (valid_o && !illegal_o && !rd_we_o));

    // R8: undefined shift-amount in the new encoding is flagged
    assert_bad_sa_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && newenc_i && !uns_i && sa_i != SA_W'(SA_LO) && sa_i != SA_W'(SA_HI))
        |=> ##1 (illegal_o && !rd_we_o));

    // R9: unsigned doubleword is flagged
    assert_uns_dword_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && uns_i && wide_i) |=> ##1 illegal_o);

    // R12: legacy encoding never targets rd
    assert_legacy_no_rd_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !newenc_i) |=> ##1 !rd_we_o);

    // R6: word results on rd are sign-extended
    assert_word_sext_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_we_o && !$past(wide_i, 2)) |-> (rd_data_o[XLEN-1:HALF] == {HALF{rd_data_o[HALF-1]}}));

    // flags only ride with a valid result
    assert_flags_qualified_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (illegal_o || rd_we_o) |-> valid_o);
endmodule

// File: tb/sim_mul_split_unit.sv
module sim_mul_split_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        start_i;
    logic [63:0] op_a_i, op_b_i;
    logic        wide_i, uns_i, newenc_i;
    logic [4:0]  sa_i;
    logic        valid_o, illegal_o, rd_we_o;
    logic [63:0] rd_data_o, hi_o, lo_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [63:0] m_hi = '0, m_lo = '0;

    always #10 clk = ~clk;

    mul_split_unit u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .op_a_i(op_a_i), .op_b_i(op_b_i), .wide_i(wide_i), .uns_i(uns_i),
        .newenc_i(newenc_i), .sa_i(sa_i), .valid_o(valid_o), .illegal_o(illegal_o),
        .rd_we_o(rd_we_o), .rd_data_o(rd_data_o), .hi_o(hi_o), .lo_o(lo_o)
    );

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] sx(input logic [31:0] v);
        return {{32{v[31]}}, v};
    endfunction

    // Reference model: updates m_hi/m_lo, returns the expected rd-side results.
    task automatic model(input logic [63:0] a, input logic [63:0] b, input logic w,
                         input logic u, input logic n, input logic [4:0] sa,
                         output logic ill, output logic we, output logic [63:0] rd,
                         output string tag);
        logic [127:0] ea, eb, p;
        ill = 0; we = 0; rd = 'x;
        if (w) begin
            ea = {{64{a[63]}}, a};
            eb = {{64{b[63]}}, b};
        end else if (u) begin
            ea = {96'b0, a[31:0]};
            eb = {96'b0, b[31:0]};
        end else begin
            ea = {{96{a[31]}}, a[31:0]};
            eb = {{96{b[31]}}, b[31:0]};
        end
        p = ea * eb;
        if (u && w) begin
            ill = 1; tag = "R9";
        end else if (u) begin
            m_lo = sx(p[31:0]); m_hi = sx(p[63:32]); tag = "R7";
        end else if (!n) begin
            tag = w ? "R3" : "R2";
            if (w) begin m_lo = p[63:0]; m_hi = p[127:64]; end
            else   begin m_lo = sx(p[31:0]); m_hi = sx(p[63:32]); end
        end else if (sa == 5'd2) begin
            we = 1; tag = "R4";
            rd = w ? p[63:0] : sx(p[31:0]);
        end else if (sa == 5'd3) begin
            we = 1; tag = "R5";
            rd = w ? p[127:64] : sx(p[63:32]);
        end else begin
            ill = 1; tag = "R8";
        end
    endtask

    task automatic drive(input logic [63:0] a, input logic [63:0] b, input logic w,
                         input logic u, input logic n, input logic [4:0] sa);
        start_i = 1; op_a_i = a; op_b_i = b; wide_i = w; uns_i = u; newenc_i = n; sa_i = sa;
    endtask

    task automatic idle();
        start_i = 0; op_a_i = $urandom; op_b_i = $urandom; sa_i = 5'($urandom);
    endtask

    task automatic compare(input string tag, input logic w, input logic n, input logic ill,
                           input logic we, input logic [63:0] rd);
        chk("R10", "valid", {63'b0, valid_o}, 64'd1);
        chk(tag, "illegal", {63'b0, illegal_o}, {63'b0, ill});
        chk(n ? tag : "R12", "rd_we", {63'b0, rd_we_o}, {63'b0, we});
        if (we) chk(w ? tag : "R6", "rd_data", rd_data_o, rd);
        chk(tag, "hi", hi_o, m_hi);
        chk(tag, "lo", lo_o, m_lo);
    endtask

    // Single request: drive at a falling edge, result read two rising edges later.
    task automatic one(input string force_tag, input logic [63:0] a, input logic [63:0] b,
                       input logic w, input logic u, input logic n, input logic [4:0] sa);
        logic ill, we; logic [63:0] rd; string tag;
        drive(a, b, w, u, n, sa);
        model(a, b, w, u, n, sa, ill, we, rd, tag);
        if (force_tag != "") tag = force_tag;
        @(negedge clk); idle();
        chk("R10", "valid_early", {63'b0, valid_o}, 64'd0);
        @(negedge clk);
        compare(tag, w, n, ill, we, rd);
        @(negedge clk);
        chk("R10", "valid_pulse", {63'b0, valid_o}, 64'd0);
    endtask

    initial begin
        void'($urandom(32'h5eed_0042));
        rst_n = 0; start_i = 0; op_a_i = '0; op_b_i = '0;
        wide_i = 0; uns_i = 0; newenc_i = 0; sa_i = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1", "valid", {63'b0, valid_o}, 64'd0);
        chk("R1", "illegal", {63'b0, illegal_o}, 64'd0);
        chk("R1", "rd_we", {63'b0, rd_we_o}, 64'd0);
        chk("R1", "rd_data", rd_data_o, 64'd0);
        chk("R1", "hi", hi_o, 64'd0);
        chk("R1", "lo", lo_o, 64'd0);

        // directed corners
        one("", 64'h0000_0000_8000_0000, 64'h0000_0000_8000_0000, 0, 0, 0, 5'd0);
        one("", 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1, 0, 0, 5'd9);
        one("", 64'hffff_ffff_ffff_ffff, 64'd1, 1, 0, 1, 5'd3);
        one("", 64'hffff_ffff_ffff_ffff, 64'd1, 0, 0, 1, 5'd3);
        one("", 64'h0000_0000_7fff_ffff, 64'h0000_0000_7fff_ffff, 0, 0, 1, 5'd2);
        one("", 64'hffff_ffff_ffff_ffff, 64'hffff_ffff_ffff_ffff, 0, 1, 1, 5'd17);
        one("", 64'h1234, 64'h5678, 0, 0, 1, 5'd0);
        one("", 64'h1234, 64'h5678, 1, 1, 0, 5'd2);
        one("", 64'h1234, 64'h5678, 1, 1, 1, 5'd3);
        one("R11", 64'hdead_beef_0000_0003, 64'h1357_9bdf_ffff_fffe, 0, 0, 1, 5'd2);
        one("R11", 64'hdead_beef_8000_0001, 64'hc0de_cafe_0000_0005, 0, 0, 0, 5'd0);

        // back-to-back: second request reads accumulators the first just wrote
        begin
            logic ill1, we1, ill2, we2; logic [63:0] rd1, rd2; string t1, t2;
            logic [63:0] h1, l1;
            drive(64'hffff_fff0, 64'h3, 0, 0, 0, 5'd0);
            model(64'hffff_fff0, 64'h3, 0, 0, 0, 5'd0, ill1, we1, rd1, t1);
            h1 = m_hi; l1 = m_lo;
            @(negedge clk);
            drive(64'h7, 64'h9, 1, 0, 1, 5'd2);
            model(64'h7, 64'h9, 1, 0, 1, 5'd2, ill2, we2, rd2, t2);
            @(negedge clk); idle();
            chk("R10", "b2b_valid1", {63'b0, valid_o}, 64'd1);
            chk("R10", "b2b_hi1", hi_o, h1);
            chk("R10", "b2b_lo1", lo_o, l1);
            @(negedge clk);
            compare(t2, 1, 1, ill2, we2, rd2);
            @(negedge clk);
            chk("R10", "b2b_idle", {63'b0, valid_o}, 64'd0);
        end

        // constrained random
        for (int i = 0; i < 400; i++) begin
            logic [63:0] a, b; logic w, u, n; logic [4:0] sa; int k;
            a = {$urandom, $urandom}; b = {$urandom, $urandom};
            k = $urandom_range(0, 9);
            if (k == 0) a = 64'h8000_0000_0000_0000;
            if (k == 1) b = '1;
            w = 1'($urandom); n = 1'($urandom);
            u = ($urandom_range(0, 4) == 0);
            sa = ($urandom_range(0, 5) == 0) ? 5'($urandom) : 5'($urandom_range(2, 3));
            one("", a, b, w, u, n, sa);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL R10 watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule